// File: doc/BRIEF.md
# JTAG Debug Chain Selector

This block sits behind one JTAG data register and splits the traffic for a debug unit that hosts several sub-modules: a system-bus access port, two CPU control ports and a serial console port. Each data-register frame is shifted in least significant bit first. The bit that arrives last is a flag. When the flag is 1 and the frame is at least three bits long, the frame is a chain-select command. The two bits shifted just before the flag become the new module index. When the flag is 0, the frame belongs to the module that is already selected, and the block leaves the selection alone.

The block runs on the TAP clock and takes the TAP controller's capture, shift and update strobes, a test-logic-reset strobe and the serial data input. It forwards the serial stream, a one-hot shift enable and a one-hot update pulse to the selected sub-module. After any reset no module is selected, and every sub-module command is dropped until a select frame arrives.

Top module: `jtag_modsel`

## Requirements
- R1: A synchronous active-high `rst` clears `sel_valid`, sets `sel_idx` to 0 and clears `fwd_en` and `fwd_update` on the next clock edge.
- R2: On `update_dr`, if at least 3 bits were shifted since the last `capture_dr` and the final bit was 1, then on the next edge `sel_idx` takes the two bits shifted just before it (the earlier one is the LSB) and `sel_valid` becomes 1. Index 0 is the system bus, 1 is CPU0, 2 is CPU1 and 3 is the serial port.
- R3: An update whose final shifted bit is 0 leaves `sel_idx` and `sel_valid` unchanged.
- R4: An update after fewer than 3 shifted bits never changes the selection, even when its last bit is 1.
- R5: `tap_reset` clears `sel_valid` on the next edge and discards the bits counted so far. It takes priority over a simultaneous update.
- R6: While a module is selected, a cycle with `shift_dr` high sets bit `sel_idx` of `fwd_en` (and only that bit) one cycle later. `fwd_tdi` is always `tdi` delayed by one cycle.
- R7: While no module is selected, `fwd_en` and `fwd_update` stay all zero.
- R8: An update that is not a select command, with a module selected and no `tap_reset`, pulses bit `sel_idx` of `fwd_update` for exactly one cycle, one cycle after `update_dr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TAP clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_reset | input | 1 | Test-logic-reset strobe from the TAP controller |
| capture_dr | input | 1 | Capture-DR strobe, starts a frame |
| shift_dr | input | 1 | Shift-DR strobe, one bit per cycle |
| update_dr | input | 1 | Update-DR strobe, ends a frame |
| tdi | input | 1 | Serial data in |
| sel_valid | output | 1 | A module is currently selected |
| sel_idx | output | IDX_W | Index of the selected module |
| fwd_tdi | output | 1 | Registered serial data to the sub-modules |
| fwd_en | output | 2**IDX_W | One-hot shift enable for the selected module |
| fwd_update | output | 2**IDX_W | One-hot update pulse for the selected module |

## Verification
The bench uses the default index width of 2, which gives all four modules, a 3-bit select frame and a bit counter that saturates at 3. With this width, frames of 0, 2, 3, 6 and 10 bits reach every counting boundary: the too-short select, the exact-length select, the longer frame whose last three bits form a select, and long sub-module commands. A behavioural model built on a queue of shifted bits predicts every output on every clock. The stimulus includes a tap reset that coincides with an update, and a reset applied in the middle of a session.

// File: rtl/jtag_modsel_pkg.sv
package jtag_modsel_pkg;
  localparam int unsigned MODSEL_IDX_W = 2;
  typedef enum logic [MODSEL_IDX_W-1:0] {
    MOD_SYSBUS = 2'd0,
    MOD_CPU0   = 2'd1,
    MOD_CPU1   = 2'd2,
    MOD_SERIAL = 2'd3
  } modsel_e;
endpackage

// File: rtl/modsel_tail.sv
// Keeps the last FRAME_W shifted bits (newest in the MSB) and a saturating bit count.
module modsel_tail #(
  parameter int unsigned FRAME_W = 3,
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               shift_en,
  input  logic               tdi,
  output logic [FRAME_W-1:0] tail,
  output logic               full
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (shift_en && (cnt != CNT_W'(FRAME_W))) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail <= '0;
    end else if (shift_en) begin
      tail <= {tdi, tail[FRAME_W-1:1]};
    end
  end

  assign full = (cnt == CNT_W'(FRAME_W));
endmodule

// File: rtl/modsel_hold.sv
// Holds the active module index and its valid flag.
module modsel_hold #(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tap_reset,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  output logic             sel_valid,
  output logic [IDX_W-1:0] sel_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_idx   <= '0;
    end else if (tap_reset) begin
      sel_valid <= 1'b0;
    end else if (load) begin
      sel_valid <= 1'b1;
      sel_idx   <= load_idx;
    end
  end
endmodule

// File: rtl/modsel_fwd.sv
// Registered per-module shift enables and update pulses.
module modsel_fwd #(
  parameter int unsigned IDX_W = 2,
  localparam int unsigned NMOD = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_valid,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             shift_in,
  input  logic             upd_in,
  input  logic             tdi,
  output logic             fwd_tdi,
  output logic [NMOD-1:0]  fwd_en,
  output logic [NMOD-1:0]  fwd_update
);
  for (genvar m = 0; m < NMOD; m++) begin : g_mod
    logic hit;
    assign hit = sel_valid && (sel_idx == IDX_W'(m));
    always_ff @(posedge clk) begin
      if (rst) begin
        fwd_en[m]     <= 1'b0;
        fwd_update[m] <= 1'b0;
      end else begin
        fwd_en[m]     <= hit && shift_in;
        fwd_update[m] <= hit && upd_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fwd_tdi <= 1'b0;
    else     fwd_tdi <= tdi;
  end
endmodule

// File: rtl/jtag_modsel.sv
module jtag_modsel #(
  parameter int unsigned IDX_W = jtag_modsel_pkg::MODSEL_IDX_W,
  localparam int unsigned NMOD    = 1 << IDX_W,
  localparam int unsigned FRAME_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tap_reset,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             sel_valid,
  output logic [IDX_W-1:0] sel_idx,
  output logic             fwd_tdi,
  output logic [NMOD-1:0]  fwd_en,
  output logic [NMOD-1:0]  fwd_update
);
  logic [FRAME_W-1:0] tail;
  logic               full;
  logic               is_select;
  logic               do_load;
  logic               sub_upd;

  modsel_tail #(.FRAME_W(FRAME_W)) u_tail (
    .clk      (clk),
    .rst      (rst),
    .clr      (capture_dr || tap_reset),
    .shift_en (shift_dr),
    .tdi      (tdi),
    .tail     (tail),
    .full     (full)
  );

  assign is_select = full && tail[FRAME_W-1];
  assign do_load   = update_dr && is_select && !tap_reset;
  assign sub_upd   = update_dr && !is_select && !tap_reset;

  modsel_hold #(.IDX_W(IDX_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .tap_reset (tap_reset),
    .load      (do_load),
    .load_idx  (tail[IDX_W-1:0]),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx)
  );

  modsel_fwd #(.IDX_W(IDX_W)) u_fwd (
    .clk        (clk),
    .rst        (rst),
    .sel_valid  (sel_valid),
    .sel_idx    (sel_idx),
    .shift_in   (shift_dr),
    .upd_in     (sub_upd),
    .tdi        (tdi),
    .fwd_tdi    (fwd_tdi),
    .fwd_en     (fwd_en),
    .fwd_update (fwd_update)
  );
endmodule

// File: rtl/jtag_modsel_chk.sv
module jtag_modsel_chk #(
  parameter int unsigned IDX_W = 2,
  localparam int unsigned NMOD = 1 << IDX_W
) (
  input logic             clk,
  input logic             rst,
  input logic             tap_reset,
  input logic             update_dr,
  input logic             sel_valid,
  input logic [IDX_W-1:0] sel_idx,
  input logic [NMOD-1:0]  fwd_en,
  input logic [NMOD-1:0]  fwd_update
);
  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !update_dr |=> $stable(sel_idx));
  // R5
  tap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    tap_reset |=> !sel_valid);
  // R6
  en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fwd_en) && $onehot0(fwd_update));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |=> (fwd_en == '0) && (fwd_update == '0));
  // R8
  upd_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_update != '0) |-> $past(update_dr));
endmodule

bind jtag_modsel jtag_modsel_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tap_reset  (tap_reset),
  .update_dr  (update_dr),
  .sel_valid  (sel_valid),
  .sel_idx    (sel_idx),
  .fwd_en     (fwd_en),
  .fwd_update (fwd_update)
);

// File: tb/jtag_modsel_tb.sv
module jtag_modsel_tb;
  localparam int IDX_W = 2;
  localparam int NMOD  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tap_reset = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic             sel_valid;
  logic [IDX_W-1:0] sel_idx;
  logic             fwd_tdi;
  logic [NMOD-1:0]  fwd_en, fwd_update;

  int checks = 0, fails = 0;
  string req = "R1";
  bit done = 1'b0;

  // reference model state
  bit     m_valid = 0;
  int     m_idx = 0;
  bit     m_tdi = 0;
  int     m_en = 0, m_upd = 0;
  bit     bits[$];

  always #5 clk = ~clk;

  jtag_modsel u_dut (
    .clk(clk), .rst(rst), .tap_reset(tap_reset), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .fwd_tdi(fwd_tdi),
    .fwd_en(fwd_en), .fwd_update(fwd_update)
  );

  always @(posedge clk) begin
    bit sel_frame;
    if (rst) begin
      m_valid = 0; m_idx = 0; m_tdi = 0; m_en = 0; m_upd = 0;
      bits.delete();
    end else begin
      sel_frame = (bits.size() >= 3) && bits[bits.size()-1];
      m_tdi = tdi;
      m_en  = (m_valid && shift_dr) ? (1 << m_idx) : 0;
      m_upd = (m_valid && update_dr && !sel_frame && !tap_reset) ? (1 << m_idx) : 0;
      if (tap_reset) m_valid = 0;
      else if (update_dr && sel_frame) begin
        m_valid = 1;
        m_idx = bits[bits.size()-3] + 2 * bits[bits.size()-2];
      end
      if (capture_dr || tap_reset) bits.delete();
      else if (shift_dr) bits.push_back(tdi);
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("sel_valid", sel_valid, m_valid);
      chk("sel_idx", sel_idx, m_idx);
      chk("fwd_tdi", fwd_tdi, m_tdi);
      chk("fwd_en", fwd_en, m_en);
      chk("fwd_update", fwd_update, m_upd);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {tap_reset, capture_dr, shift_dr, update_dr} = '0;
    end
  endtask

  // shifts val[0] first; val[n-1] is the flag bit
  task automatic frame(int n, logic [15:0] val, bit tap_at_update = 0);
    @(negedge clk); {tap_reset, shift_dr, update_dr} = '0; capture_dr = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); capture_dr = 0; shift_dr = 1; tdi = val[i];
    end
    @(negedge clk); capture_dr = 0; shift_dr = 0; update_dr = 1; tap_reset = tap_at_update;
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = "R1"; chk("reset valid", sel_valid, 0); chk("reset idx", sel_idx, 0);
    rst = 0;
    idle(1);
    req = "R7"; frame(8, 16'h00A5);
    req = "R2"; frame(3, 16'b101);            // select CPU0
    chk("idx CPU0", sel_idx, 1);
    req = "R6"; frame(10, 16'h0155);           // sub command, flag 0
    req = "R8"; frame(6, 16'b011011);
    req = "R3"; chk("idx kept", sel_idx, 1);
    req = "R2"; frame(3, 16'b111);            // serial port
    chk("idx serial", sel_idx, 3);
    req = "R2"; frame(6, 16'b110101);         // longer frame, CPU1
    chk("idx CPU1", sel_idx, 2);
    req = "R4"; frame(2, 16'b11);
    chk("short ignored", sel_idx, 2);
    req = "R4"; frame(0, 16'b0);
    req = "R8"; frame(4, 16'b0110);
    req = "R5"; @(negedge clk); tap_reset = 1; idle(2);
    chk("tap cleared", sel_valid, 0);
    req = "R7"; frame(5, 16'b01111);
    req = "R2"; frame(3, 16'b100);            // system bus
    chk("idx bus", sel_idx, 0);
    req = "R5"; frame(3, 16'b110, 1);         // tap reset wins over select
    chk("tap priority", sel_valid, 0);
    req = "R2"; frame(3, 16'b111);
    req = "R1"; @(negedge clk); rst = 1; idle(2);
    chk("mid reset valid", sel_valid, 0); rst = 0;
    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule